// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block serves the host side of a network controller's data port. Each host strobe moves one, two or four bytes between the host and the card's buffer memory, at the address held in the remote pointer. After the access the pointer moves on by the access size and the remote byte count drops by the same amount. When the count runs out, a one-cycle completion pulse goes to the interrupt logic.

The buffer memory sits inside the block and has two windows with a hole between them. The first is a 32-byte identity window that holds the station address, set at reset. The second is the packet RAM, which starts at `PKT_BASE`. Every other address is a hole: it reads back as all ones and takes no write. The receive path gets a separate byte-wide write port into the packet RAM. The register decoder loads the pointer and count, and it supplies the ring start and stop pages that make the pointer wrap.

Top module: `rdma_port`

## Requirements
- R1: Addresses 0 to 31 form a readable and writable identity window. After reset, byte k (k = 0..5) holds bits [47-8k:40-8k] of `STATION_MAC`, bytes 14 and 15 hold 0x57, and every other byte holds 0xFF.
- R2: Each byte of an access is decoded on its own address. A byte outside both the identity window and [PKT_BASE, PKT_BASE+PKT_BYTES) reads as 0xFF and ignores writes.
- R3: `acc_size` code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes.
- R4: For 2- and 4-byte accesses the block clears bit 0 of the pointer before use. A 1-byte access uses the pointer unchanged.
- R5: Multi-byte data is little-endian: the byte at the lowest address travels on bits [7:0]. `rd_data` bits above the access width read as zero.
- R6: A read strobe in cycle n gives `rd_valid` high and the data on `rd_data` after the clock edge that ends cycle n. The same edge updates the pointer and the count. A write never raises `rd_valid`.
- R7: After each performed access the pointer becomes the old (unaligned) pointer plus the access size. If that sum equals `stop_pg`*256, the pointer takes `start_pg`*256 instead.
- R8: If the count before an access is less than or equal to the access size, it becomes zero and `dma_done` is high for that one cycle. Otherwise the count drops by the access size.
- R9: A write strobe while the count is zero changes no memory, pointer or count, and raises no `dma_done`. A read while the count is zero still goes ahead and raises `dma_done`.
- R10: `ptr_load` and `cnt_load` set the pointer and count. They win over the update from an access in the same cycle, and that access still uses the old pointer. After reset the pointer and the count are zero.
- R11: The receive port writes one byte into the packet RAM if its address is mapped and ignores it otherwise. When a host write lands on the same byte in the same cycle, the host data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_pg | input | 8 | Ring start page (byte address = page*256) |
| stop_pg | input | 8 | Ring stop page (byte address = page*256) |
| ptr_load | input | 1 | Load the remote pointer from `ptr_wval` |
| ptr_wval | input | 16 | Value for pointer load |
| cnt_load | input | 1 | Load the remote byte count from `cnt_wval` |
| cnt_wval | input | 16 | Value for count load |
| acc_req | input | 1 | Host data-port access strobe, one per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| rdma_ptr | output | 16 | Current remote pointer |
| rdma_cnt | output | 16 | Current remote byte count |
| dma_done | output | 1 | One-cycle pulse when the count is exhausted |
| rx_we | input | 1 | Receive-side byte write strobe |
| rx_addr | input | 16 | Receive-side byte address |
| rx_wdata | input | 8 | Receive-side byte data |

## Verification
The bench fills the whole packet RAM with 2-byte writes and reads it all back with 4-byte reads. It then runs several hundred random accesses against a byte model of both windows. The targeted cases are these:
- 4-byte reads that straddle either edge of the packet RAM. A design that decodes only the start address would return RAM bytes where 0xFF belongs, or the reverse.
- Odd pointers on 2-byte accesses, which show whether bit 0 is cleared for the memory access but kept in the pointer that is carried forward.
- A count of exactly zero, where a design that does not block the write would change memory or move the pointer.
- A sum that hits the stop page, and a collision between a receive write and a host write on the same byte. These catch a wrong or missing wrap and the wrong winner.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  localparam int unsigned LANES = 4;

  // number of bytes moved for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rdma_prom.sv
module rdma_prom #(
  parameter int unsigned AW         = 16,
  parameter int unsigned LANES      = 4,
  parameter int unsigned PROM_BYTES = 32,
  parameter logic [47:0] MAC        = 48'h5254_0012_3456
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           lane_wen,
  input  logic [LANES-1:0][AW-1:0]   lane_addr,
  input  logic [LANES-1:0][7:0]      lane_wd,
  output logic [LANES-1:0][7:0]      lane_rd,
  output logic [LANES-1:0]           lane_hit
);

  localparam int unsigned PW = $clog2(PROM_BYTES);

  logic [7:0] rom_q [PROM_BYTES];
  logic [7:0] rom_d [PROM_BYTES];
  logic       rom_en;

  function automatic logic [7:0] init_byte(input int unsigned k);
    if (k < 6)                  init_byte = MAC[8*(5-k) +: 8];
    else if (k == 14 || k == 15) init_byte = 8'h57;
    else                        init_byte = 8'hFF;
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_hit[i] = lane_addr[i] < AW'(PROM_BYTES);
      lane_rd[i]  = rom_q[lane_addr[i][PW-1:0]];
    end
  end

  always_comb begin
    rom_en = 1'b0;
    for (int k = 0; k < PROM_BYTES; k++) rom_d[k] = rom_q[k];
    for (int i = 0; i < LANES; i++) begin
      if (lane_wen[i] && lane_hit[i]) begin
        rom_d[lane_addr[i][PW-1:0]] = lane_wd[i];
        rom_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PROM_BYTES; k++) rom_q[k] <= init_byte(k);
    end else if (rom_en) begin
      for (int k = 0; k < PROM_BYTES; k++) rom_q[k] <= rom_d[k];
    end
  end

endmodule

// File: rtl/rdma_pktram.sv
module rdma_pktram #(
  parameter int unsigned AW        = 16,
  parameter int unsigned LANES     = 4,
  parameter int unsigned PKT_BASE  = 32'h4000,
  parameter int unsigned PKT_BYTES = 1024
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           lane_wen,
  input  logic [LANES-1:0][AW-1:0]   lane_addr,
  input  logic [LANES-1:0][7:0]      lane_wd,
  output logic [LANES-1:0][7:0]      lane_rd,
  output logic [LANES-1:0]           lane_hit,
  input  logic                       rx_we,
  input  logic [AW-1:0]              rx_addr,
  input  logic [7:0]                 rx_wdata
);

  localparam int unsigned IW = $clog2(PKT_BYTES);
  localparam logic [AW:0] LO = (AW+1)'(PKT_BASE);
  localparam logic [AW:0] HI = (AW+1)'(PKT_BASE + PKT_BYTES);

  logic [7:0]          mem_q [PKT_BYTES];
  logic [LANES-1:0][IW-1:0] lane_idx;
  logic                rx_hit;
  logic [IW-1:0]       rx_idx;

  function automatic logic in_range(input logic [AW-1:0] a);
    in_range = ({1'b0, a} >= LO) && ({1'b0, a} < HI);
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_hit[i] = in_range(lane_addr[i]);
      lane_idx[i] = IW'(lane_addr[i] - AW'(PKT_BASE));
      lane_rd[i]  = mem_q[lane_idx[i]];
    end
    rx_hit = rx_we && in_range(rx_addr);
    rx_idx = IW'(rx_addr - AW'(PKT_BASE));
  end

  // host lanes are written after the receive byte, so they win a collision
  always_ff @(posedge clk) begin
    if (rx_hit) mem_q[rx_idx] <= rx_wdata;
    for (int i = 0; i < LANES; i++) begin
      if (lane_wen[i] && lane_hit[i]) mem_q[lane_idx[i]] <= lane_wd[i];
    end
  end

endmodule

// File: rtl/rdma_ptrcnt.sv
module rdma_ptrcnt #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_req,
  input  logic          acc_we,
  input  logic [2:0]    nbytes,
  input  logic [7:0]    start_pg,
  input  logic [7:0]    stop_pg,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_val,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_val,
  output logic [AW-1:0] ptr_q,
  output logic [CW-1:0] cnt_q,
  output logic          done_q,
  output logic          wr_open
);

  logic          go;
  logic          ptr_en, cnt_en, done_d;
  logic [AW-1:0] ptr_d, ptr_adv, start_b, stop_b;
  logic [CW-1:0] cnt_d;

  assign wr_open = (cnt_q != '0);
  assign go      = acc_req && (!acc_we || wr_open);
  assign start_b = AW'({start_pg, 8'h00});
  assign stop_b  = AW'({stop_pg, 8'h00});

  always_comb begin
    ptr_adv = ptr_q + AW'(nbytes);
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    if (go) begin
      ptr_d  = (ptr_adv == stop_b) ? start_b : ptr_adv;
      ptr_en = 1'b1;
    end
    if (ptr_load) begin
      ptr_d  = ptr_val;
      ptr_en = 1'b1;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = 1'b0;
    if (go) begin
      cnt_en = 1'b1;
      if (cnt_q <= CW'(nbytes)) begin
        cnt_d  = '0;
        done_d = !cnt_load;
      end else begin
        cnt_d = cnt_q - CW'(nbytes);
      end
    end
    if (cnt_load) begin
      cnt_d  = cnt_val;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  // R8: completion only ever reports an empty count
  p_done_means_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));

  // R8: an access never makes the count grow
  p_cnt_never_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !cnt_load) |=> (cnt_q <= $past(cnt_q)));

  // R9: a write at zero count leaves pointer and count untouched
  p_blocked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_we && (cnt_q == '0) && !ptr_load && !cnt_load)
      |=> ($stable(ptr_q) && $stable(cnt_q) && !done_q));

endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int unsigned AW          = 16,
  parameter int unsigned CW          = 16,
  parameter int unsigned PKT_BASE    = 32'h4000,
  parameter int unsigned PKT_BYTES   = 1024,
  parameter int unsigned PROM_BYTES  = 32,
  parameter logic [47:0] STATION_MAC = 48'h5254_0012_3456
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    start_pg,
  input  logic [7:0]    stop_pg,
  input  logic          ptr_load,
  input  logic [15:0]   ptr_wval,
  input  logic          cnt_load,
  input  logic [15:0]   cnt_wval,
  input  logic          acc_req,
  input  logic          acc_we,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [15:0]   rdma_ptr,
  output logic [15:0]   rdma_cnt,
  output logic          dma_done,
  input  logic          rx_we,
  input  logic [15:0]   rx_addr,
  input  logic [7:0]    rx_wdata
);
  import rdma_pkg::*;

  logic [1:0]              rst_sync_q;
  logic                    rst_n_s;
  logic [2:0]              nbytes;
  logic [AW-1:0]           ptr_q, base_addr;
  logic [CW-1:0]           cnt_q;
  logic                    wr_open, done_q;
  logic [LANES-1:0][AW-1:0] lane_addr;
  logic [LANES-1:0]        lane_on, lane_wen;
  logic [LANES-1:0][7:0]   lane_wd, lane_rd;
  logic [LANES-1:0][7:0]   prom_rd, pkt_rd;
  logic [LANES-1:0]        prom_hit, pkt_hit;
  logic [31:0]             rd_d, rd_q;
  logic                    rd_en, rd_valid_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign nbytes    = size_bytes(acc_size);
  assign base_addr = (nbytes == 3'd1) ? ptr_q : {ptr_q[AW-1:1], 1'b0};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = base_addr + AW'(g);
    assign lane_on[g]   = (3'(g) < nbytes);
    assign lane_wen[g]  = acc_req && acc_we && wr_open && lane_on[g];
    assign lane_wd[g]   = acc_wdata[8*g +: 8];
    assign lane_rd[g]   = !lane_on[g] ? 8'h00 :
                          prom_hit[g] ? prom_rd[g] :
                          pkt_hit[g]  ? pkt_rd[g]  : 8'hFF;
  end
  assign rd_d  = lane_rd;
  assign rd_en = acc_req && !acc_we;

  rdma_prom #(
    .AW(AW), .LANES(LANES), .PROM_BYTES(PROM_BYTES), .MAC(STATION_MAC)
  ) prom_i (
    .clk(clk), .rst_n(rst_n_s),
    .lane_wen(lane_wen), .lane_addr(lane_addr), .lane_wd(lane_wd),
    .lane_rd(prom_rd), .lane_hit(prom_hit)
  );

  rdma_pktram #(
    .AW(AW), .LANES(LANES), .PKT_BASE(PKT_BASE), .PKT_BYTES(PKT_BYTES)
  ) ram_i (
    .clk(clk),
    .lane_wen(lane_wen), .lane_addr(lane_addr), .lane_wd(lane_wd),
    .lane_rd(pkt_rd), .lane_hit(pkt_hit),
    .rx_we(rx_we), .rx_addr(AW'(rx_addr)), .rx_wdata(rx_wdata)
  );

  rdma_ptrcnt #(.AW(AW), .CW(CW)) pc_i (
    .clk(clk), .rst_n(rst_n_s),
    .acc_req(acc_req), .acc_we(acc_we), .nbytes(nbytes),
    .start_pg(start_pg), .stop_pg(stop_pg),
    .ptr_load(ptr_load), .ptr_val(AW'(ptr_wval)),
    .cnt_load(cnt_load), .cnt_val(CW'(cnt_wval)),
    .ptr_q(ptr_q), .cnt_q(cnt_q), .done_q(done_q), .wr_open(wr_open)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rd_valid_q;
  assign rdma_ptr = 16'(ptr_q);
  assign rdma_cnt = 16'(cnt_q);
  assign dma_done = done_q;

  // R6: read data is flagged only one cycle after a read strobe
  p_rdvalid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_valid |-> $past(acc_req && !acc_we));

  // R5: a single-byte read carries zeros above bit 7
  p_byte_read_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid && ($past(acc_size) == SZ_BYTE)) |-> (rd_data[31:8] == 24'h0));

endmodule

// File: tb/rdma_port_tb_top.sv
`timescale 1ns/1ps
module rdma_port_tb_top;

  logic        clk, rst_n;
  logic [7:0]  start_pg, stop_pg;
  logic        ptr_load, cnt_load;
  logic [15:0] ptr_wval, cnt_wval;
  logic        acc_req, acc_we;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        rd_valid, dma_done;
  logic [15:0] rdma_ptr, rdma_cnt;
  logic        rx_we;
  logic [15:0] rx_addr;
  logic [7:0]  rx_wdata;

  rdma_port dut_i (
    .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
    .ptr_load(ptr_load), .ptr_wval(ptr_wval), .cnt_load(cnt_load), .cnt_wval(cnt_wval),
    .acc_req(acc_req), .acc_we(acc_we), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rdma_ptr(rdma_ptr), .rdma_cnt(rdma_cnt),
    .dma_done(dma_done), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [7:0]  m_prom [32];
  logic [7:0]  m_pkt  [1024];
  logic [15:0] e_ptr, e_cnt;

  function automatic logic mapped_pkt(input logic [15:0] a);
    return (a >= 16'h4000) && (a < 16'h4400);
  endfunction

  function automatic logic [7:0] mread(input logic [15:0] a);
    if (a < 16'd32)     return m_prom[a[4:0]];
    if (mapped_pkt(a))  return m_pkt[a[9:0]];
    return 8'hFF;
  endfunction

  task automatic mwrite(input logic [15:0] a, input logic [7:0] d);
    if (a < 16'd32)         m_prom[a[4:0]] = d;
    else if (mapped_pkt(a)) m_pkt[a[9:0]] = d;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] p, input logic [15:0] c);
    @(negedge clk);
    ptr_load = 1'b1; ptr_wval = p; cnt_load = 1'b1; cnt_wval = c;
    @(negedge clk);
    ptr_load = 1'b0; cnt_load = 1'b0;
    e_ptr = p; e_cnt = c;
    check("R10 load ptr", 32'(rdma_ptr), 32'(e_ptr));
    check("R10 load cnt", 32'(rdma_cnt), 32'(e_cnt));
  endtask

  task automatic step(input logic req, input logic we, input logic [1:0] sz,
                      input logic [31:0] wd, input logic rxe, input logic [15:0] rxa,
                      input logic [7:0] rxd, input logic pl, input logic [15:0] pv,
                      input string tag);
    int          nb;
    logic [15:0] base, nxt;
    logic        blocked, exp_done, rx_lost;
    logic [31:0] exp_rd;
    nb       = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    base     = (nb == 1) ? e_ptr : {e_ptr[15:1], 1'b0};
    blocked  = we && (e_cnt == 16'd0);
    exp_rd   = '0;
    exp_done = 1'b0;
    rx_lost  = 1'b0;
    if (req && !blocked) begin
      for (int i = 0; i < nb; i++) begin
        logic [15:0] a;
        a = base + 16'(i);
        if (we) begin
          mwrite(a, wd[8*i +: 8]);
          if (rxe && rxa == a) rx_lost = 1'b1;
        end else begin
          exp_rd[8*i +: 8] = mread(a);
        end
      end
      nxt = e_ptr + 16'(nb);
      if (nxt == {stop_pg, 8'h00}) nxt = {start_pg, 8'h00};
      e_ptr = nxt;
      if (e_cnt <= 16'(nb)) begin e_cnt = 16'd0; exp_done = 1'b1; end
      else e_cnt = e_cnt - 16'(nb);
    end
    if (rxe && !rx_lost) mwrite_rx(rxa, rxd);
    if (pl) e_ptr = pv;
    @(negedge clk);
    acc_req = req; acc_we = we; acc_size = sz; acc_wdata = wd;
    rx_we = rxe; rx_addr = rxa; rx_wdata = rxd;
    ptr_load = pl; ptr_wval = pv;
    @(negedge clk);
    acc_req = 1'b0; rx_we = 1'b0; ptr_load = 1'b0;
    check({tag, " R6 rd_valid"}, 32'(rd_valid), 32'(req && !we));
    if (req && !we) check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " R8 done"}, 32'(dma_done), 32'(exp_done));
    check({tag, " R7 ptr"}, 32'(rdma_ptr), 32'(e_ptr));
    check({tag, " R8 cnt"}, 32'(rdma_cnt), 32'(e_cnt));
  endtask

  task automatic mwrite_rx(input logic [15:0] a, input logic [7:0] d);
    if (mapped_pkt(a)) m_pkt[a[9:0]] = d;
  endtask

  task automatic rd(input logic [1:0] sz, input string tag);
    step(1'b1, 1'b0, sz, 32'h0, 1'b0, 16'h0, 8'h0, 1'b0, 16'h0, tag);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] wd, input string tag);
    step(1'b1, 1'b1, sz, wd, 1'b0, 16'h0, 8'h0, 1'b0, 16'h0, tag);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements) act=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start_pg = 8'h40; stop_pg = 8'h44;
    ptr_load = 0; cnt_load = 0; ptr_wval = 0; cnt_wval = 0;
    acc_req = 0; acc_we = 0; acc_size = 0; acc_wdata = 0;
    rx_we = 0; rx_addr = 0; rx_wdata = 0;
    for (int k = 0; k < 32; k++) m_prom[k] = 8'hFF;
    m_prom[0] = 8'h52; m_prom[1] = 8'h54; m_prom[2] = 8'h00;
    m_prom[3] = 8'h12; m_prom[4] = 8'h34; m_prom[5] = 8'h56;
    m_prom[14] = 8'h57; m_prom[15] = 8'h57;
    for (int k = 0; k < 1024; k++) m_pkt[k] = 8'h00;
    e_ptr = 0; e_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R10, R6)
    check("R10 reset ptr", 32'(rdma_ptr), 32'h0);
    check("R10 reset cnt", 32'(rdma_cnt), 32'h0);
    check("R8 reset done", 32'(dma_done), 32'h0);
    check("R6 reset rd_valid", 32'(rd_valid), 32'h0);
    check("R6 reset rd_data", rd_data, 32'h0);

    // R1: identity window contents, byte reads at zero count (R9 read side)
    for (int k = 0; k < 32; k++) rd(2'd0, "R1 prom byte");
    load(16'h0000, 16'd40);
    for (int k = 0; k < 16; k++) rd(2'd1, "R5 prom half");
    // R1 writable window
    load(16'h0010, 16'd4);
    wr(2'd2, 32'hA1B2_C3D4, "R1 prom write");
    load(16'h0010, 16'd8);
    for (int k = 0; k < 4; k++) rd(2'd0, "R5 prom byte order");

    // R2: fill packet RAM with 2-byte writes, last one wraps (R7)
    load(16'h4000, 16'd1024);
    for (int k = 0; k < 512; k++)
      wr(2'd1, {16'h0, 8'(k * 7 + 3), 8'(k ^ 8'h5A)}, "R2 fill");
    load(16'h4000, 16'd1024);
    for (int k = 0; k < 256; k++) rd(2'd2, "R3 word readback");

    // R2: holes
    load(16'h0100, 16'd8);
    wr(2'd2, 32'h1122_3344, "R2 hole write");
    load(16'h0100, 16'd8);
    rd(2'd2, "R2 hole read");
    load(16'h3FFE, 16'd8);
    rd(2'd2, "R2 straddle low edge");
    load(16'h43FE, 16'd8);
    rd(2'd2, "R2 straddle high edge");
    load(16'h001E, 16'd8);
    rd(2'd2, "R2 straddle window end");

    // R4: odd pointer
    load(16'h4011, 16'd10);
    wr(2'd1, 32'h0000_BEEF, "R4 odd half write");
    load(16'h4010, 16'd10);
    rd(2'd0, "R4 byte at even");
    rd(2'd0, "R4 byte at odd");
    load(16'h4023, 16'd10);
    rd(2'd2, "R4 odd word read");

    // R8 / R9: count edges
    load(16'h4040, 16'd3);
    wr(2'd2, 32'hCAFE_F00D, "R8 short count write");
    wr(2'd0, 32'h0000_0099, "R9 blocked write");
    wr(2'd2, 32'h7777_7777, "R9 blocked word write");
    load(16'h4044, 16'd0);
    rd(2'd0, "R9 read at zero count");
    load(16'h4040, 16'd5);
    rd(2'd1, "R8 count 5->3");
    rd(2'd1, "R8 count 3->1");
    rd(2'd1, "R8 count 1->0");

    // R7: wrap from unaligned pointer and with another start page
    load(16'h43FF, 16'd20);
    rd(2'd0, "R7 byte wrap");
    start_pg = 8'h42;
    load(16'h43FC, 16'd20);
    rd(2'd2, "R7 word wrap to start");
    load(16'h43FD, 16'd20);
    rd(2'd1, "R7 odd half no wrap");
    start_pg = 8'h40;

    // R10: load wins over access update
    load(16'h4080, 16'd20);
    step(1'b1, 1'b0, 2'd2, 32'h0, 1'b0, 16'h0, 8'h0, 1'b1, 16'h4100, "R10 load vs read");
    rd(2'd0, "R10 after load");

    // R11: receive port
    step(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 16'h4050, 8'h3C, 1'b0, 16'h0, "R11 rx write");
    step(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 16'h4500, 8'h3C, 1'b0, 16'h0, "R11 rx hole");
    load(16'h4050, 16'd20);
    rd(2'd0, "R11 rx readback");
    load(16'h4500, 16'd20);
    rd(2'd0, "R11 rx hole readback");
    load(16'h4060, 16'd20);
    step(1'b1, 1'b1, 2'd0, 32'h11, 1'b1, 16'h4060, 8'h22, 1'b0, 16'h0, "R11 collision");
    load(16'h4060, 16'd20);
    step(1'b1, 1'b1, 2'd0, 32'h33, 1'b1, 16'h4061, 8'h44, 1'b0, 16'h0, "R11 neighbour");
    load(16'h4060, 16'd20);
    rd(2'd1, "R11 collision readback");

    // R3: size code 3
    load(16'h4070, 16'd20);
    wr(2'd3, 32'h8899_AABB, "R3 code3 write");
    load(16'h4070, 16'd20);
    rd(2'd3, "R3 code3 read");

    // random mix
    for (int it = 0; it < 600; it++) begin
      if (it % 6 == 0) begin
        logic [15:0] p;
        if ($urandom % 4 == 0) p = 16'($urandom % 40);
        else p = 16'h3FF0 + 16'($urandom % 16'h420);
        load(p, 16'($urandom % 24));
      end
      step(1'b1, 1'($urandom % 2), 2'($urandom % 4), $urandom,
           ($urandom % 4 == 0), 16'h4000 + 16'($urandom % 1024), 8'($urandom),
           1'b0, 16'h0, "R3 random");
    end

    finish_run();
  end

endmodule